// File: doc/BRIEF.md
# UART Transmitter with Idle Queueing

This block serialises characters onto one output line. Software writes a byte, plus an optional ninth bit, into a single holding buffer. When the shifter is free, the byte moves into a frame shift register. The frame holds a low start bit, the data bits least significant first, the ninth bit when nine-bit mode is on, and a high stop bit. Each bit lasts sixteen pulses of the `baud_tick` input.

When the transmitter is switched on, it first sends a synchronising idle character: a whole frame time of ones. Switching the enable off lets the current character finish and then leaves the line idle. Turning the enable off and on again while a character is shifting schedules one extra idle character after that character. If the enable comes back only after the shifter has gone quiet, the pending byte is discarded. A polarity bit inverts every symbol on the line.

Two status flags report the state of the transmitter. One says the holding buffer is free. The other says everything has drained. Each flag has its own interrupt enable, and the two enabled flags are ORed into one request.

Top module: `uart_tx_idleq`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1, `tx_done` is 1 and `irq` is 0.
- R2: When the enable goes from 0 to 1, one idle character is sent before any data frame. The idle character is 10 bit times of ones in 8-bit mode and 11 bit times in 9-bit mode.
- R3: A data frame is sent in this order: a start bit of 0, the 8 data bits with the LSB first, the ninth bit (`wbit9`) only when `ctl_nine` is 1, and a stop bit of 1. Each bit is 16 baud ticks long.
- R4: The shifter advances only on cycles with `baud_tick` high. Ticks on every other clock make each bit 32 clocks long.
- R5: Clearing the enable while a frame is shifting lets that frame complete. After it, the line stays idle and no further frame starts.
- R6: Clearing and then setting the enable while a frame is shifting sends one idle character right after that frame, followed by the byte held in the buffer.
- R7: While the enable is 0 and the shifter is quiet, the buffer is discarded and `buf_empty` reads 1. Re-enabling afterwards sends only the idle preamble and none of the discarded data.
- R8: With `ctl_inv` at 1, every symbol on `txd` is inverted, including the idle level, start bits and stop bits.
- R9: `buf_empty` drops in the cycle after a write to `wr_data`. It rises again once the byte has moved into the shift register.
- R10: `tx_done` is 1 only when the shifter is quiet, the buffer is empty, no idle character is pending or being sent, and `brk_req` is 0. A write to `wr_data` clears it.
- R11: `irq` equals (`buf_empty` AND empty interrupt enable) OR (`tx_done` AND done interrupt enable). A pulse on `wr_ctrl` writes the enables together with `ctl_en`, `ctl_nine` and `ctl_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversampling tick; 16 ticks make one bit |
| wr_data | input | 1 | Write strobe for the holding buffer |
| wdata | input | DATA_W | Data byte to transmit |
| wbit9 | input | 1 | Ninth bit, sent in 9-bit mode |
| wr_ctrl | input | 1 | Write strobe for the control bits |
| ctl_en | input | 1 | Transmitter enable |
| ctl_nine | input | 1 | 1 selects 9-bit characters |
| ctl_inv | input | 1 | 1 inverts the output line |
| ctl_ie_empty | input | 1 | Interrupt enable for buffer empty |
| ctl_ie_done | input | 1 | Interrupt enable for transmission complete |
| brk_req | input | 1 | Break request; holds `tx_done` low |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding buffer is free |
| tx_done | output | 1 | Transmission complete |
| irq | output | 1 | Interrupt request |

## Verification
The frame decoder is run on four byte patterns:
- Alternating bits, which exposes bit-order and off-by-one shifts.
- A 9-bit character, which separates the ninth bit from the stop bit and lengthens the preamble.
- A half-rate tick, which shows the bit time follows the tick and not the clock.
- An inverted line, which must decode only once the polarity is undone.

The enable is exercised in three ways: cleared during a frame, toggled during a frame, and restored only after the frame. The gap before the next start bit tells apart a queued idle character, an immediate resend and a dropped byte.

// File: rtl/uart_tx_idleq.sv
module uart_tx_idleq #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wbit9,
  input  logic              wr_ctrl,
  input  logic              ctl_en,
  input  logic              ctl_nine,
  input  logic              ctl_inv,
  input  logic              ctl_ie_empty,
  input  logic              ctl_ie_done,
  input  logic              brk_req,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_done,
  output logic              irq
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int BIT_CW  = $clog2(FRAME_W + 1);
  localparam int TICK_CW = $clog2(OVERSAMPLE);

  logic en_q, nine_q, inv_q, ie_e_q, ie_d_q;
  logic [DATA_W-1:0] buf_q;
  logic buf9_q, buf_full, idle_pend;
  logic active;
  logic [FRAME_W-1:0] sh_q;
  logic [BIT_CW-1:0]  bits_left;
  logic [TICK_CW-1:0] tick_q;
  logic [FRAME_W-1:0] data_frame;

  wire en_rise   = wr_ctrl & ctl_en & ~en_q;
  wire can_load  = ~active & en_q;
  wire load_idle = can_load & idle_pend;
  wire load_data = can_load & ~idle_pend & buf_full;
  wire drop      = ~active & ~en_q;
  wire bit_end   = active & baud_tick & (tick_q == TICK_CW'(OVERSAMPLE - 1));
  wire [BIT_CW-1:0] frame_len = nine_q ? BIT_CW'(FRAME_W) : BIT_CW'(FRAME_W - 1);

  always_comb begin
    data_frame = '1;
    data_frame[0] = 1'b0;
    data_frame[DATA_W:1] = buf_q;
    if (nine_q) data_frame[DATA_W+1] = buf9_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; nine_q <= 1'b0; inv_q <= 1'b0; ie_e_q <= 1'b0; ie_d_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q <= ctl_en; nine_q <= ctl_nine; inv_q <= ctl_inv;
      ie_e_q <= ctl_ie_empty; ie_d_q <= ctl_ie_done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_pend <= 1'b0;
    else if (en_rise) idle_pend <= 1'b1;
    else if (drop | load_idle) idle_pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0; buf_q <= '0; buf9_q <= 1'b0;
    end else if (wr_data) begin
      buf_full <= 1'b1; buf_q <= wdata; buf9_q <= wbit9;
    end else if (drop | load_data) begin
      buf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; sh_q <= '1; bits_left <= '0; tick_q <= '0;
    end else if (load_idle | load_data) begin
      active    <= 1'b1;
      sh_q      <= load_idle ? '1 : data_frame;
      bits_left <= frame_len;
      tick_q    <= '0;
    end else if (active & baud_tick) begin
      if (bit_end) begin
        tick_q    <= '0;
        sh_q      <= {1'b1, sh_q[FRAME_W-1:1]};
        bits_left <= bits_left - 1'b1;
        if (bits_left == BIT_CW'(1)) active <= 1'b0;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign txd       = (active ? sh_q[0] : 1'b1) ^ inv_q;
  assign buf_empty = ~buf_full;
  assign tx_done   = ~active & ~buf_full & ~idle_pend & ~brk_req;
  assign irq       = (buf_empty & ie_e_q) | (tx_done & ie_d_q);

  // R4
  stall_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !baud_tick) |=> ($stable(sh_q) && $stable(bits_left)));

  // R10
  done_implies_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> buf_empty);

  // R10
  write_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (!tx_done && !buf_empty));

  // R7
  drop_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !active && !wr_data) |=> buf_empty);

  // R9
  load_frees_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_data && !wr_data) |=> (buf_empty && active));

  // R3
  bits_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (bits_left != '0 && bits_left <= BIT_CW'(FRAME_W)));

endmodule

// File: tb/uart_tx_idleq_tb.sv
`timescale 1ns/1ps
module uart_tx_idleq_tb;
  logic clk = 0, rst_n = 0, baud_tick = 1, half = 0;
  logic wr_data = 0, wbit9 = 0, wr_ctrl = 0;
  logic [7:0] wdata = 0;
  logic ctl_en = 0, ctl_nine = 0, ctl_inv = 0, ctl_ie_empty = 0, ctl_ie_done = 0, brk_req = 0;
  logic txd, buf_empty, tx_done, irq;
  logic c_en, c_nine, c_inv, c_ie_e, c_ie_d;
  int n_chk = 0, n_err = 0;
  bit done_flag = 0;

  uart_tx_idleq u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_data(wr_data), .wdata(wdata),
    .wbit9(wbit9), .wr_ctrl(wr_ctrl), .ctl_en(ctl_en), .ctl_nine(ctl_nine), .ctl_inv(ctl_inv),
    .ctl_ie_empty(ctl_ie_empty), .ctl_ie_done(ctl_ie_done), .brk_req(brk_req),
    .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done), .irq(irq));

  always #10 clk = ~clk;
  always @(negedge clk) baud_tick <= half ? ~baud_tick : 1'b1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; half = 0; brk_req = 0; wr_data = 0; wr_ctrl = 0;
    c_en = 0; c_nine = 0; c_inv = 0; c_ie_e = 0; c_ie_d = 0;
    ctl_en = 0; ctl_nine = 0; ctl_inv = 0; ctl_ie_empty = 0; ctl_ie_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr_cfg();
    wr_ctrl = 1; ctl_en = c_en; ctl_nine = c_nine; ctl_inv = c_inv;
    ctl_ie_empty = c_ie_e; ctl_ie_done = c_ie_d;
    @(negedge clk);
    wr_ctrl = 0;
  endtask

  task automatic wr_byte(input logic [7:0] d, input logic b9);
    wr_data = 1; wdata = d; wbit9 = b9;
    @(negedge clk);
    wr_data = 0;
  endtask

  task automatic wait_start(input int limit, output int n);
    n = 0;
    while (((txd ^ c_inv) == 1'b1) && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  // mode: 0 plain, 1 disable, 2 disable+enable+write nb, 3 disable+write nb
  task automatic read_frame(input int cpb, input int mode, input logic [7:0] nb,
                            output logic [7:0] d, output logic b9, output logic stp, output logic st);
    int used = 0;
    if (mode != 0) begin
      wr_ctrl = 1; c_en = 0; ctl_en = 0;
      @(negedge clk); used++;
      if (mode == 2) begin
        c_en = 1; ctl_en = 1;
        @(negedge clk); used++;
      end
      wr_ctrl = 0;
      if (mode >= 2) begin wr_byte(nb, 1'b0); used++; end
    end
    while (used < cpb / 2 - 1) begin @(negedge clk); used++; end
    st = txd ^ c_inv;
    for (int i = 0; i < 8; i++) begin
      repeat (cpb) @(negedge clk);
      d[i] = txd ^ c_inv;
    end
    b9 = 1'b0;
    if (c_nine) begin repeat (cpb) @(negedge clk); b9 = txd ^ c_inv; end
    repeat (cpb) @(negedge clk);
    stp = txd ^ c_inv;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "txd", txd, 1);
    chk("R1", "buf_empty", buf_empty, 1);
    chk("R1", "tx_done", tx_done, 1);
    chk("R1", "irq", irq, 0);
  endtask

  task automatic t_basic();
    int n; logic [7:0] d; logic b9, sp, st;
    do_reset();
    c_en = 1; wr_cfg();
    wr_byte(8'hA5, 1'b0);
    wait_start(400, n);
    chk_rng("R2", "preamble length 8-bit", n, 155, 170);
    read_frame(16, 0, 8'h00, d, b9, sp, st);
    chk("R3", "start bit", st, 0);
    chk("R3", "data LSB first", d, 8'hA5);
    chk("R3", "stop bit", sp, 1);
  endtask

  task automatic t_nine();
    int n; logic [7:0] d; logic b9, sp, st;
    do_reset();
    c_en = 1; c_nine = 1; wr_cfg();
    wr_byte(8'h3C, 1'b1);
    wait_start(400, n);
    chk_rng("R2", "preamble length 9-bit", n, 171, 186);
    read_frame(16, 0, 8'h00, d, b9, sp, st);
    chk("R3", "9-bit data", d, 8'h3C);
    chk("R3", "ninth bit", b9, 1);
    chk("R3", "9-bit stop", sp, 1);
  endtask

  task automatic t_half();
    int n; logic [7:0] d; logic b9, sp, st;
    do_reset();
    half = 1;
    c_en = 1; wr_cfg();
    wr_byte(8'h96, 1'b0);
    wait_start(800, n);
    chk_rng("R4", "preamble at half-rate tick", n, 312, 336);
    read_frame(32, 0, 8'h00, d, b9, sp, st);
    chk("R4", "half-rate data", d, 8'h96);
    chk("R4", "half-rate stop", sp, 1);
    half = 0;
  endtask

  task automatic t_inv();
    int n; logic [7:0] d; logic b9, sp, st;
    do_reset();
    c_inv = 1; wr_cfg();
    chk("R8", "inverted idle level", txd, 0);
    c_en = 1; wr_cfg();
    wr_byte(8'h5A, 1'b0);
    wait_start(400, n);
    chk_rng("R8", "inverted preamble length", n, 155, 170);
    read_frame(16, 0, 8'h00, d, b9, sp, st);
    chk("R8", "inverted start", st, 0);
    chk("R8", "inverted data", d, 8'h5A);
    chk("R8", "inverted stop", sp, 1);
  endtask

  task automatic t_flags();
    int n;
    do_reset();
    c_en = 1; c_ie_d = 1; wr_cfg();
    chk("R10", "done low while preamble pending", tx_done, 0);
    chk("R11", "irq low with done low", irq, 0);
    wr_byte(8'h11, 1'b0);
    chk("R9", "empty low after write", buf_empty, 0);
    chk("R10", "done low after write", tx_done, 0);
    wait_start(400, n);
    chk("R9", "empty high after load", buf_empty, 1);
    chk("R10", "done low while shifting", tx_done, 0);
    chk("R11", "irq low, empty ie off", irq, 0);
    c_ie_e = 1; wr_cfg();
    chk("R11", "irq from empty flag", irq, 1);
    repeat (200) @(negedge clk);
    chk("R10", "done after drain", tx_done, 1);
    c_ie_e = 0; c_ie_d = 0; wr_cfg();
    chk("R11", "irq masked", irq, 0);
    c_ie_d = 1; wr_cfg();
    chk("R11", "irq from done flag", irq, 1);
  endtask

  task automatic t_break();
    do_reset();
    chk("R10", "done before break", tx_done, 1);
    brk_req = 1; @(negedge clk);
    chk("R10", "break holds done low", tx_done, 0);
    brk_req = 0; @(negedge clk);
    chk("R10", "done after break", tx_done, 1);
  endtask

  task automatic t_disable();
    int n; logic [7:0] d; logic b9, sp, st;
    do_reset();
    c_en = 1; wr_cfg();
    wr_byte(8'hC3, 1'b0);
    wait_start(400, n);
    read_frame(16, 1, 8'h00, d, b9, sp, st);
    chk("R5", "frame completes after disable", d, 8'hC3);
    chk("R5", "stop after disable", sp, 1);
    wait_start(400, n);
    chk("R5", "line idle after disable", n, 400);
    chk("R5", "done after disable", tx_done, 1);
  endtask

  task automatic t_toggle();
    int n; logic [7:0] d; logic b9, sp, st;
    do_reset();
    c_en = 1; wr_cfg();
    wr_byte(8'h81, 1'b0);
    wait_start(400, n);
    read_frame(16, 2, 8'h7E, d, b9, sp, st);
    chk("R6", "first char", d, 8'h81);
    wait_start(600, n);
    chk_rng("R6", "queued idle gap", n, 160, 178);
    read_frame(16, 0, 8'h00, d, b9, sp, st);
    chk("R6", "buffered char after idle", d, 8'h7E);
  endtask

  task automatic t_late();
    int n; logic [7:0] d; logic b9, sp, st;
    do_reset();
    c_en = 1; wr_cfg();
    wr_byte(8'h42, 1'b0);
    wait_start(400, n);
    read_frame(16, 3, 8'hE7, d, b9, sp, st);
    chk("R7", "frame before late enable", d, 8'h42);
    repeat (30) @(negedge clk);
    chk("R7", "buffer discarded", buf_empty, 1);
    c_en = 1; wr_cfg();
    wait_start(500, n);
    chk("R7", "no data after late enable", n, 500);
    chk("R7", "buffer still empty", buf_empty, 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_nine();
    t_half();
    t_inv();
    t_flags();
    t_break();
    t_disable();
    t_toggle();
    t_late();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule